// File: doc/BRIEF.md
# Compare, Branch and Linkage Unit

This block produces the condition code and the control-transfer decision for a 24-bit accumulator machine. Each cycle it takes one operation select, together with the accumulator, the index register, the link register, one register-file read value, a memory operand word, a target address and the address of the following instruction. Compare operations compare signed 24-bit values and record less, equal or greater in a 2-bit condition-code register. The index-step operations first add one to the index register and then compare the new value. Three conditional jumps test that code. A subroutine call saves the return address in the link register, and a return jumps back to the address held there.

The write enables, write data, next program counter and illegal-register flag are combinational in the operation's own cycle. The condition code is registered and changes at the clock edge that ends a compare operation. A jump in the very next cycle therefore sees the new code. Reset is asynchronous, active low, and is released through a two-stage synchronizer.

Top module: `cbl_unit`

## Requirements
- R1: After reset the condition code output reads 01 (equal). The code values are 00 less, 01 equal and 10 greater, and 11 never appears.
- R2: Operation 1 (compare with memory) compares A and the memory word as signed 24-bit values. It sets the condition code at the next clock edge and writes neither X nor L.
- R3: Operation 2 (compare with register) compares A with the register whose number is on r1_sel. Number 0 selects A, number 1 selects X, and every other legal number selects rf_rdata. The result is set as in R2.
- R4: Operation 3 (step index, compare memory) raises x_we and drives x_wdata = X+1 modulo 2^24. It then sets the condition code from the signed compare of that new X with the memory word.
- R5: Operation 4 (step index, compare register) behaves as R4 but compares against the register named on r1_sel. Number 1 means the incremented X, so the result is equal.
- R6: For operations 2 and 4, the register numbers 6, 7 and 10 to 15 raise ill_reg in the same cycle and leave the condition code unchanged. Operation 4 still writes X+1.
- R7: Operations 5, 6 and 7 (jump on less, equal, greater) set pc_next to tgt_addr when the condition code is 00, 01 or 10 respectively. Otherwise pc_next is next_addr.
- R8: Operation 8 (call) raises l_we, drives l_wdata with next_addr zero-extended to 24 bits, and sets pc_next to tgt_addr.
- R9: Operation 9 (return) sets pc_next to the low 20 bits of l_val and writes neither X nor L.
- R10: Operation 0 and the unused codes 10 to 15 give pc_next = next_addr, no writes, ill_reg low, and an unchanged condition code.
- R11: A jump issued in the cycle right after a compare acts on the code that compare produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation select |
| r1_sel | input | 4 | Register number for the register-operand operations |
| a_val | input | 24 | Accumulator value |
| x_val | input | 24 | Index register value |
| l_val | input | 24 | Link register value |
| rf_rdata | input | 24 | Register-file read value for r1_sel |
| mem_word | input | 24 | Memory operand word |
| tgt_addr | input | 20 | Target address |
| next_addr | input | 20 | Address of the following instruction |
| cc_out | output | 2 | Condition code |
| pc_next | output | 20 | Next program counter |
| x_we | output | 1 | Index register write enable |
| x_wdata | output | 24 | Index register write data |
| l_we | output | 1 | Link register write enable |
| l_wdata | output | 24 | Link register write data |
| ill_reg | output | 1 | Illegal register number flag |

## Verification
The index increment and the register compare happen in the same cycle when the step-and-compare-register operation names X as its operand. The compare must then use the incremented value and not the stale x_val. The bench sets up this case by driving rf_rdata with an unrelated value and x_val with a value that would compare unequal without forwarding. It then requires the equal code after the clock edge. A second pairing, a compare followed at once by each jump, checks that the jump acts on the freshly registered code.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_CMPM = 4'd1,
    OP_CMPR = 4'd2,
    OP_INCM = 4'd3,
    OP_INCR = 4'd4,
    OP_JLT  = 4'd5,
    OP_JEQ  = 4'd6,
    OP_JGT  = 4'd7,
    OP_CALL = 4'd8,
    OP_RET  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    CC_LT = 2'b00,
    CC_EQ = 2'b01,
    CC_GT = 2'b10
  } cc_e;
endpackage

// File: rtl/cbl_rst_sync.sv
module cbl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic s1, s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= 1'b1;
      s2 <= s1;
    end
  end
  assign rst_q_n = s2;
endmodule

// File: rtl/cbl_opsel.sv
module cbl_opsel #(
  parameter int DW = 24,
  parameter int RW = 4
) (
  input  logic [3:0]    op_sel,
  input  logic [RW-1:0] r1_sel,
  input  logic [DW-1:0] a_val,
  input  logic [DW-1:0] x_val,
  input  logic [DW-1:0] rf_rdata,
  input  logic [DW-1:0] mem_word,
  output logic [DW-1:0] lhs,
  output logic [DW-1:0] rhs,
  output logic [DW-1:0] x_inc,
  output logic          is_incr,
  output logic          cmp_en,
  output logic          ill
);
  import cbl_pkg::*;
  localparam int NREG = 2 ** RW;

  logic [NREG-1:0] legal_vec;
  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_legal
      assign legal_vec[g] = (g <= 5) || (g == 8) || (g == 9);
    end
  endgenerate

  logic is_reg, is_cmp;
  logic [DW-1:0] reg_op;

  always_comb begin
    is_incr = (op_sel == OP_INCM) || (op_sel == OP_INCR);
    is_reg  = (op_sel == OP_CMPR) || (op_sel == OP_INCR);
    is_cmp  = (op_sel == OP_CMPM) || is_reg || is_incr;
    x_inc   = x_val + DW'(1);
    unique case (r1_sel)
      RW'(0):  reg_op = a_val;
      RW'(1):  reg_op = is_incr ? x_inc : x_val;
      default: reg_op = rf_rdata;
    endcase
    lhs    = is_incr ? x_inc : a_val;
    rhs    = is_reg ? reg_op : mem_word;
    ill    = is_reg && !legal_vec[r1_sel];
    cmp_en = is_cmp && !ill;
  end
endmodule

// File: rtl/cbl_cmp.sv
module cbl_cmp #(
  parameter int DW = 24
) (
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [1:0]    res
);
  import cbl_pkg::*;
  always_comb begin
    if ($signed(lhs) < $signed(rhs))      res = CC_LT;
    else if (lhs == rhs)                  res = CC_EQ;
    else                                  res = CC_GT;
  end
endmodule

// File: rtl/cbl_ccreg.sv
module cbl_ccreg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] d,
  output logic [1:0] q
);
  import cbl_pkg::*;
  logic [1:0] q_nxt;
  always_comb q_nxt = en ? d : q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CC_EQ;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/cbl_branch.sv
module cbl_branch #(
  parameter int DW = 24,
  parameter int AW = 20
) (
  input  logic [3:0]    op_sel,
  input  logic [1:0]    cc,
  input  logic [AW-1:0] tgt_addr,
  input  logic [AW-1:0] next_addr,
  input  logic [DW-1:0] l_val,
  output logic [AW-1:0] pc_next,
  output logic          l_we,
  output logic [DW-1:0] l_wdata
);
  import cbl_pkg::*;
  localparam int PADW = DW - AW;

  always_comb begin
    pc_next = next_addr;
    l_we    = 1'b0;
    l_wdata = {{PADW{1'b0}}, next_addr};
    case (op_sel)
      OP_JLT:  if (cc == CC_LT) pc_next = tgt_addr;
      OP_JEQ:  if (cc == CC_EQ) pc_next = tgt_addr;
      OP_JGT:  if (cc == CC_GT) pc_next = tgt_addr;
      OP_CALL: begin
        pc_next = tgt_addr;
        l_we    = 1'b1;
      end
      OP_RET:  pc_next = l_val[AW-1:0];
      default: pc_next = next_addr;
    endcase
  end
endmodule

// File: rtl/cbl_unit.sv
module cbl_unit #(
  parameter int DW = 24,
  parameter int AW = 20,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_sel,
  input  logic [RW-1:0] r1_sel,
  input  logic [DW-1:0] a_val,
  input  logic [DW-1:0] x_val,
  input  logic [DW-1:0] l_val,
  input  logic [DW-1:0] rf_rdata,
  input  logic [DW-1:0] mem_word,
  input  logic [AW-1:0] tgt_addr,
  input  logic [AW-1:0] next_addr,
  output logic [1:0]    cc_out,
  output logic [AW-1:0] pc_next,
  output logic          x_we,
  output logic [DW-1:0] x_wdata,
  output logic          l_we,
  output logic [DW-1:0] l_wdata,
  output logic          ill_reg
);
  logic          rst_q_n;
  logic [DW-1:0] lhs, rhs, x_inc;
  logic          is_incr, cmp_en;
  logic [1:0]    cmp_res;

  cbl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  cbl_opsel #(.DW(DW), .RW(RW)) u_opsel (
    .op_sel(op_sel), .r1_sel(r1_sel), .a_val(a_val), .x_val(x_val),
    .rf_rdata(rf_rdata), .mem_word(mem_word), .lhs(lhs), .rhs(rhs),
    .x_inc(x_inc), .is_incr(is_incr), .cmp_en(cmp_en), .ill(ill_reg)
  );

  cbl_cmp #(.DW(DW)) u_cmp (.lhs(lhs), .rhs(rhs), .res(cmp_res));

  cbl_ccreg u_cc (
    .clk(clk), .rst_n(rst_q_n), .en(cmp_en), .d(cmp_res), .q(cc_out)
  );

  cbl_branch #(.DW(DW), .AW(AW)) u_br (
    .op_sel(op_sel), .cc(cc_out), .tgt_addr(tgt_addr), .next_addr(next_addr),
    .l_val(l_val), .pc_next(pc_next), .l_we(l_we), .l_wdata(l_wdata)
  );

  assign x_we    = is_incr;
  assign x_wdata = x_inc;
endmodule

// File: rtl/cbl_unit_chk.sv
module cbl_unit_chk #(
  parameter int DW = 24,
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op_sel,
  input logic [DW-1:0] a_val,
  input logic [DW-1:0] x_val,
  input logic [DW-1:0] l_val,
  input logic [DW-1:0] mem_word,
  input logic [AW-1:0] tgt_addr,
  input logic [AW-1:0] next_addr,
  input logic [1:0]    cc_out,
  input logic [AW-1:0] pc_next,
  input logic          x_we,
  input logic [DW-1:0] x_wdata,
  input logic          l_we,
  input logic [DW-1:0] l_wdata,
  input logic          ill_reg
);
  a_r1_cc_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cc_out != 2'b11);

  a_r2_cmp_less: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd1 && $signed(a_val) < $signed(mem_word)) |=> cc_out == 2'b00);

  a_r4_step_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd3) |-> (x_we && x_wdata == x_val + DW'(1)));

  a_r6_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ill_reg |=> cc_out == $past(cc_out));

  a_r7_jeq_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd6 && cc_out == 2'b01) |-> pc_next == tgt_addr);

  a_r8_call: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd8) |-> (l_we && l_wdata[AW-1:0] == next_addr && pc_next == tgt_addr));

  a_r9_return: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd9) |-> (pc_next == l_val[AW-1:0] && !l_we && !x_we));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd0 || op_sel >= 4'd10) |=> cc_out == $past(cc_out));

  a_r10_idle_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd0 || op_sel >= 4'd10) |-> (!x_we && !l_we && !ill_reg && pc_next == next_addr));
endmodule

bind cbl_unit cbl_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .op_sel(op_sel), .a_val(a_val), .x_val(x_val),
  .l_val(l_val), .mem_word(mem_word), .tgt_addr(tgt_addr), .next_addr(next_addr),
  .cc_out(cc_out), .pc_next(pc_next), .x_we(x_we), .x_wdata(x_wdata),
  .l_we(l_we), .l_wdata(l_wdata), .ill_reg(ill_reg)
);

// File: tb/sim_cbl_unit.sv
module sim_cbl_unit;
  logic        clk, rst_n;
  logic [3:0]  op_sel, r1_sel;
  logic [23:0] a_val, x_val, l_val, rf_rdata, mem_word;
  logic [19:0] tgt_addr, next_addr;
  logic [1:0]  cc_out;
  logic [19:0] pc_next;
  logic        x_we, l_we, ill_reg;
  logic [23:0] x_wdata, l_wdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  cbl_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .r1_sel(r1_sel),
    .a_val(a_val), .x_val(x_val), .l_val(l_val), .rf_rdata(rf_rdata),
    .mem_word(mem_word), .tgt_addr(tgt_addr), .next_addr(next_addr),
    .cc_out(cc_out), .pc_next(pc_next), .x_we(x_we), .x_wdata(x_wdata),
    .l_we(l_we), .l_wdata(l_wdata), .ill_reg(ill_reg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [19:0] TGT = 20'hA5A50;
  localparam logic [19:0] NXT = 20'h01234;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [3:0] r1,
                        input logic [23:0] a, input logic [23:0] x,
                        input logic [23:0] rf, input logic [23:0] mem,
                        input logic [23:0] l);
    @(negedge clk);
    op_sel = op; r1_sel = r1; a_val = a; x_val = x; rf_rdata = rf;
    mem_word = mem; l_val = l; tgt_addr = TGT; next_addr = NXT;
    #2;
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    chk("R1 reset code", {30'd0, cc_out}, 32'd1);
    run_op(4'd0, 4'd0, 24'd1, 24'd2, 24'd3, 24'd4, 24'd5);
    chk("R10 nop pc", {12'd0, pc_next}, {12'd0, NXT});
    chk("R10 nop writes", {30'd0, x_we, l_we}, 32'd0);
    settle();
    chk("R10 nop code held", {30'd0, cc_out}, 32'd1);
  endtask

  task automatic t_compare_mem();
    run_op(4'd1, 4'd0, 24'hFFFFFF, 24'd0, 24'd0, 24'd1, 24'd0);
    chk("R2 no writes", {30'd0, x_we, l_we}, 32'd0);
    settle();
    chk("R2 signed less", {30'd0, cc_out}, 32'd0);
    run_op(4'd1, 4'd0, 24'd5, 24'd0, 24'd0, 24'd5, 24'd0);
    settle();
    chk("R2 equal", {30'd0, cc_out}, 32'd1);
    run_op(4'd1, 4'd0, 24'd1, 24'd0, 24'd0, 24'hFFFFFF, 24'd0);
    settle();
    chk("R2 signed greater", {30'd0, cc_out}, 32'd2);
  endtask

  task automatic t_jumps();
    run_op(4'd1, 4'd0, 24'd2, 24'd0, 24'd0, 24'd9, 24'd0);
    settle();
    run_op(4'd5, 4'd0, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0);
    chk("R11 jlt right after compare", {12'd0, pc_next}, {12'd0, TGT});
    run_op(4'd6, 4'd0, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0);
    chk("R7 jeq not taken", {12'd0, pc_next}, {12'd0, NXT});
    run_op(4'd7, 4'd0, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0);
    chk("R7 jgt not taken", {12'd0, pc_next}, {12'd0, NXT});
    run_op(4'd1, 4'd0, 24'd9, 24'd0, 24'd0, 24'd2, 24'd0);
    settle();
    run_op(4'd7, 4'd0, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0);
    chk("R11 jgt right after compare", {12'd0, pc_next}, {12'd0, TGT});
    run_op(4'd5, 4'd0, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0);
    chk("R7 jlt not taken", {12'd0, pc_next}, {12'd0, NXT});
    run_op(4'd1, 4'd0, 24'd7, 24'd0, 24'd0, 24'd7, 24'd0);
    settle();
    run_op(4'd6, 4'd0, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0);
    chk("R7 jeq taken", {12'd0, pc_next}, {12'd0, TGT});
  endtask

  task automatic t_linkage();
    run_op(4'd8, 4'd0, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0);
    chk("R8 call pc", {12'd0, pc_next}, {12'd0, TGT});
    chk("R8 call l_we", {31'd0, l_we}, 32'd1);
    chk("R8 call l_wdata", {8'd0, l_wdata}, {12'd0, NXT});
    run_op(4'd9, 4'd0, 24'd0, 24'd0, 24'd0, 24'd0, 24'hF54321);
    chk("R9 return pc", {12'd0, pc_next}, 32'h54321);
    chk("R9 return writes", {30'd0, x_we, l_we}, 32'd0);
  endtask

  task automatic t_step_mem();
    run_op(4'd3, 4'd0, 24'd0, 24'd4, 24'd0, 24'd5, 24'd0);
    chk("R4 x_we", {31'd0, x_we}, 32'd1);
    chk("R4 x_wdata", {8'd0, x_wdata}, 32'd5);
    settle();
    chk("R4 new X equals mem", {30'd0, cc_out}, 32'd1);
    run_op(4'd3, 4'd0, 24'd0, 24'h7FFFFF, 24'd0, 24'd0, 24'd0);
    chk("R4 wrap data", {8'd0, x_wdata}, 32'h800000);
    settle();
    chk("R4 wrapped X is negative", {30'd0, cc_out}, 32'd0);
  endtask

  task automatic t_step_reg();
    run_op(4'd4, 4'd5, 24'd0, 24'd2, 24'd10, 24'd0, 24'd0);
    settle();
    chk("R5 vs register 5 less", {30'd0, cc_out}, 32'd0);
    run_op(4'd4, 4'd1, 24'd0, 24'd9, 24'd3, 24'd100, 24'd0);
    chk("R5 x_wdata", {8'd0, x_wdata}, 32'd10);
    settle();
    chk("R5 against incremented X equal", {30'd0, cc_out}, 32'd1);
    run_op(4'd4, 4'd0, 24'd3, 24'd3, 24'd50, 24'd0, 24'd0);
    settle();
    chk("R5 vs A greater", {30'd0, cc_out}, 32'd2);
  endtask

  task automatic t_compare_reg();
    run_op(4'd2, 4'd9, 24'd50, 24'd0, 24'd100, 24'd0, 24'd0);
    chk("R3 no ill", {31'd0, ill_reg}, 32'd0);
    settle();
    chk("R3 vs register 9 less", {30'd0, cc_out}, 32'd0);
    run_op(4'd2, 4'd1, 24'd50, 24'd50, 24'd0, 24'd0, 24'd0);
    chk("R3 no X write", {31'd0, x_we}, 32'd0);
    settle();
    chk("R3 vs X equal", {30'd0, cc_out}, 32'd1);
  endtask

  task automatic t_illegal();
    run_op(4'd1, 4'd0, 24'd9, 24'd0, 24'd0, 24'd1, 24'd0);
    settle();
    run_op(4'd2, 4'd6, 24'd0, 24'd0, 24'd100, 24'd0, 24'd0);
    chk("R6 ill on 6", {31'd0, ill_reg}, 32'd1);
    settle();
    chk("R6 code held after 6", {30'd0, cc_out}, 32'd2);
    run_op(4'd4, 4'd12, 24'd0, 24'd0, 24'd100, 24'd0, 24'd0);
    chk("R6 ill on 12", {31'd0, ill_reg}, 32'd1);
    chk("R6 X still written", {31'd0, x_we}, 32'd1);
    settle();
    chk("R6 code held after 12", {30'd0, cc_out}, 32'd2);
    run_op(4'd2, 4'd7, 24'd0, 24'd0, 24'd100, 24'd0, 24'd0);
    chk("R6 ill on 7", {31'd0, ill_reg}, 32'd1);
  endtask

  task automatic t_unused();
    run_op(4'd12, 4'd6, 24'd0, 24'd0, 24'd0, 24'd0, 24'd0);
    chk("R10 unused pc", {12'd0, pc_next}, {12'd0, NXT});
    chk("R10 unused flags", {29'd0, x_we, l_we, ill_reg}, 32'd0);
    settle();
    chk("R10 unused code held", {30'd0, cc_out}, 32'd2);
  endtask

  initial begin
    rst_n = 1'b0;
    op_sel = 4'd0; r1_sel = 4'd0; a_val = '0; x_val = '0; l_val = '0;
    rf_rdata = '0; mem_word = '0; tgt_addr = '0; next_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    t_reset();
    t_compare_mem();
    t_jumps();
    t_linkage();
    t_step_mem();
    t_step_reg();
    t_compare_reg();
    t_illegal();
    t_unused();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule